// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block turns a decoded load/store request into the data-space address the memory stage should use. A request carries an addressing-mode code, a pointer select, a full 16-bit direct address and a 6-bit displacement. The three 16-bit pointers come from the six highest entries of a 32-entry byte-wide register file. These six bytes enter as one flat bus. For the modes that change a pointer, the block also returns the new pointer value, the register-file index of its low byte and a write-back strobe. The register-file write port uses these three outputs.

A request is sampled on a rising clock edge while `reqValid` is high. The result appears after that edge as one registered cycle of `effValid`. Requests may be issued back to back. A combination that the block cannot serve raises `illegal`. In that case the address is forced to zero and nothing is written back.

Top module: `agu_top`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `effValid`, `wbEn` and `illegal` are 0 and `effAddr` is 0.
- R2: A request sampled at a rising edge with `reqValid`=1 shows its result after that edge, with `effValid`=1, until the next edge. After an edge where `reqValid`=0, `effValid`, `wbEn` and `illegal` are 0.
- R3: Mode codes on `reqMode`: 0 direct, 1 indirect, 2 displacement, 3 pre-decrement, 4 post-increment. Pointer codes on `reqPtr`: 0 X, 1 Y, 2 Z.
- R4: Byte k of `rfTop` (bits 8k+7:8k) is register-file entry 26+k. Each pointer is little-endian: X is entries 27:26, Y is 29:28 and Z is 31:30, with the high byte first.
- R5: In direct mode `effAddr` equals `directAddr`. The pointers and `reqPtr` are ignored, `wbEn` is 0 and `illegal` is 0.
- R6: In indirect mode `effAddr` equals the selected pointer, with no write-back.
- R7: In displacement mode with Y or Z, `effAddr` is the pointer plus `disp` (0 to 63), modulo 65536, with no write-back.
- R8: Displacement mode with X sets `illegal`=1 and `wbEn`=0, and `effAddr` is 0.
- R9: In pre-decrement mode, `effAddr` and `wbValue` both equal the pointer minus 1, modulo 65536. `wbEn` is 1 and `wbRegLo` is the pointer's low-byte index (26, 28 or 30).
- R10: In post-increment mode, `effAddr` is the unchanged pointer and `wbValue` is the pointer plus 1, modulo 65536. `wbEn` is 1 and `wbRegLo` is the low-byte index.
- R11: A mode code of 5 to 7, or pointer code 3 in a pointer mode, sets `illegal`=1 and `wbEn`=0, and `effAddr` is 0.
- R12: `wbEn` is 1 only for a legal pre-decrement or post-increment request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqMode | input | 3 | Addressing-mode code |
| reqPtr | input | 2 | Pointer select |
| directAddr | input | 16 | Full address for direct mode |
| disp | input | 6 | Unsigned displacement |
| rfTop | input | 48 | Register-file entries 26..31, entry 26 in the low byte |
| effValid | output | 1 | Result valid |
| effAddr | output | 16 | Effective data address |
| wbEn | output | 1 | Pointer write-back strobe |
| wbRegLo | output | 5 | Register index of the written pointer's low byte |
| wbValue | output | 16 | Updated pointer value |
| illegal | output | 1 | Request could not be served |

## Verification
All state sits in one output register stage, so a wrong decode or a wrong sum shows up at the ports on the very cycle after the request. Swapped pointer bytes, a wrong base index or a carry that does not wrap all change `effAddr` or `wbValue` at once. The vectors therefore use pointer values of 0x0000, 0xFFFF and values with distinct high and low bytes. A write-back strobe that leaks into the wrong mode changes `wbEn` in that same cycle. Because the register holds no history, no error can remain hidden for later cycles.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int ADDR_W = 16;
  localparam int DISP_W = 6;
  localparam int RF_DEPTH = 32;
  localparam int NUM_PTR = 3;
  localparam int RF_IDX_W = $clog2(RF_DEPTH);
  localparam int PTR_BASE = RF_DEPTH - 2 * NUM_PTR;

  typedef enum logic [2:0] {
    MODE_DIRECT  = 3'd0,
    MODE_IND     = 3'd1,
    MODE_DISP    = 3'd2,
    MODE_PREDEC  = 3'd3,
    MODE_POSTINC = 3'd4
  } addrMode_e;

  localparam logic [1:0] PTR_X = 2'd0;

  typedef struct packed {
    logic useDirect;
    logic addDisp;
    logic decr;
    logic incr;
    logic wbEn;
    logic illegal;
  } ctrlStrobes_t;
endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
#(
  parameter int NPTR = NUM_PTR
) (
  input  logic [2:0]   reqMode,
  input  logic [1:0]   reqPtr,
  output ctrlStrobes_t strobes
);
  logic ptrOk;
  assign ptrOk = (int'(reqPtr) < NPTR);

  always_comb begin
    strobes = '0;
    case (reqMode)
      MODE_DIRECT:  strobes.useDirect = 1'b1;
      MODE_IND:     strobes.illegal = !ptrOk;
      MODE_DISP: begin
        strobes.addDisp = 1'b1;
        strobes.illegal = !ptrOk || (reqPtr == PTR_X);
      end
      MODE_PREDEC: begin
        strobes.decr    = 1'b1;
        strobes.illegal = !ptrOk;
        strobes.wbEn    = ptrOk;
      end
      MODE_POSTINC: begin
        strobes.incr    = 1'b1;
        strobes.illegal = !ptrOk;
        strobes.wbEn    = ptrOk;
      end
      default:      strobes.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int DW   = DISP_W,
  parameter int NPTR = NUM_PTR,
  parameter int IW   = RF_IDX_W,
  parameter int BASE = PTR_BASE
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqPtr,
  input  logic [AW-1:0]       directAddr,
  input  logic [DW-1:0]       disp,
  input  logic [NPTR*AW-1:0]  rfTop,
  input  ctrlStrobes_t        strobes,
  output logic                effValid,
  output logic [AW-1:0]       effAddr,
  output logic                wbEn,
  output logic [IW-1:0]       wbRegLo,
  output logic [AW-1:0]       wbValue,
  output logic                illegal
);
  localparam int BYTE_W = AW / 2;

  logic [AW-1:0] ptrArr [NPTR];

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    assign ptrArr[i] = {rfTop[(2*i+1)*BYTE_W +: BYTE_W], rfTop[2*i*BYTE_W +: BYTE_W]};
  end

  logic [AW-1:0] base, baseDec, baseInc, baseDisp, addrNext, wbNext;
  logic [IW-1:0] regNext;

  always_comb begin
    base = '0;
    for (int i = 0; i < NPTR; i++)
      if (int'(reqPtr) == i) base = ptrArr[i];
  end

  assign baseDec  = base - AW'(1);
  assign baseInc  = base + AW'(1);
  assign baseDisp = base + AW'(disp);
  assign regNext  = IW'(BASE) + IW'({reqPtr, 1'b0});

  always_comb begin
    if (strobes.illegal)        addrNext = '0;
    else if (strobes.useDirect) addrNext = directAddr;
    else if (strobes.decr)      addrNext = baseDec;
    else if (strobes.addDisp)   addrNext = baseDisp;
    else                        addrNext = base;
    wbNext = strobes.decr ? baseDec : baseInc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      effValid <= 1'b0;
      effAddr  <= '0;
      wbEn     <= 1'b0;
      wbRegLo  <= '0;
      wbValue  <= '0;
      illegal  <= 1'b0;
    end else begin
      effValid <= reqValid;
      wbEn     <= reqValid && strobes.wbEn;
      illegal  <= reqValid && strobes.illegal;
      if (reqValid) begin
        effAddr <= addrNext;
        wbRegLo <= regNext;
        wbValue <= wbNext;
      end
    end
  end
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [2:0]              reqMode,
  input  logic [1:0]              reqPtr,
  input  logic [ADDR_W-1:0]       directAddr,
  input  logic [DISP_W-1:0]       disp,
  input  logic [NUM_PTR*ADDR_W-1:0] rfTop,
  output logic                    effValid,
  output logic [ADDR_W-1:0]       effAddr,
  output logic                    wbEn,
  output logic [RF_IDX_W-1:0]     wbRegLo,
  output logic [ADDR_W-1:0]       wbValue,
  output logic                    illegal
);
  ctrlStrobes_t strobes;

  agu_ctrl #(.NPTR(NUM_PTR)) u_ctrl (
    .reqMode (reqMode),
    .reqPtr  (reqPtr),
    .strobes (strobes)
  );

  agu_datapath #(
    .AW(ADDR_W), .DW(DISP_W), .NPTR(NUM_PTR), .IW(RF_IDX_W), .BASE(PTR_BASE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqPtr     (reqPtr),
    .directAddr (directAddr),
    .disp       (disp),
    .rfTop      (rfTop),
    .strobes    (strobes),
    .effValid   (effValid),
    .effAddr    (effAddr),
    .wbEn       (wbEn),
    .wbRegLo    (wbRegLo),
    .wbValue    (wbValue),
    .illegal    (illegal)
  );
endmodule

// File: rtl/agu_checker.sv
module agu_checker
  import agu_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic                      reqValid,
  input logic [2:0]                reqMode,
  input logic [1:0]                reqPtr,
  input logic [ADDR_W-1:0]         directAddr,
  input logic [DISP_W-1:0]         disp,
  input logic [NUM_PTR*ADDR_W-1:0] rfTop,
  input logic                      effValid,
  input logic [ADDR_W-1:0]         effAddr,
  input logic                      wbEn,
  input logic [RF_IDX_W-1:0]       wbRegLo,
  input logic [ADDR_W-1:0]         wbValue,
  input logic                      illegal
);
  logic [ADDR_W-1:0] ptrY;
  assign ptrY = {rfTop[31:24], rfTop[23:16]};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> effValid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!effValid && !wbEn && !illegal)); // R2
  AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == MODE_DIRECT) |=> (effAddr == $past(directAddr) && !illegal && !wbEn)); // R5
  AST_DISP_Y_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == MODE_DISP && reqPtr == 2'd1) |=> (effAddr == $past(ptrY + ADDR_W'(disp)))); // R7
  AST_DISP_X_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == MODE_DISP && reqPtr == PTR_X) |=> (illegal && !wbEn && effAddr == '0)); // R8
  AST_PREDEC_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == MODE_PREDEC && reqPtr != 2'd3) |=> (wbEn && effAddr == wbValue)); // R9
  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == MODE_POSTINC && reqPtr != 2'd3) |=> (wbEn && wbValue == effAddr + 16'd1)); // R10
  AST_WB_ONLY_AUTO: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode != MODE_PREDEC && reqMode != MODE_POSTINC) |=> !wbEn); // R12
  AST_WB_REG_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> (effValid && !illegal && (wbRegLo == 5'd26 || wbRegLo == 5'd28 || wbRegLo == 5'd30))); // R9
endmodule

bind agu_top agu_checker u_chk (.*);

// File: tb/tb_agu_top.sv
module tb_agu_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqMode = '0;
  logic [1:0] reqPtr = '0;
  logic [15:0] directAddr = '0;
  logic [5:0] disp = '0;
  logic [47:0] rfTop = '0;
  logic effValid, wbEn, illegal;
  logic [15:0] effAddr, wbValue;
  logic [4:0] wbRegLo;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  agu_top dut (.*);

  typedef struct packed {
    logic [2:0]  mode;
    logic [1:0]  ptr;
    logic [15:0] dir;
    logic [5:0]  dsp;
    logic [47:0] rf;
    logic [15:0] expAddr;
    logic        expWb;
    logic [15:0] expVal;
    logic [4:0]  expReg;
    logic        expIll;
  } vec_t;

  // rfA: X=1234 Y=0000 Z=FFFF ; rfB: X=0000 Y=8001 Z=00FF
  localparam logic [47:0] RFA = 48'hFFFF_0000_1234;
  localparam logic [47:0] RFB = 48'h00FF_8001_0000;
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 16'hABCD, 6'd0,  RFA, 16'hABCD, 1'b0, 16'h0, 5'd0,  1'b0}, // R5
    '{3'd1, 2'd0, 16'h0,    6'd0,  RFA, 16'h1234, 1'b0, 16'h0, 5'd0,  1'b0}, // R6 R4
    '{3'd2, 2'd1, 16'h0,    6'd63, RFA, 16'h003F, 1'b0, 16'h0, 5'd0,  1'b0}, // R7
    '{3'd2, 2'd2, 16'h0,    6'd1,  RFA, 16'h0000, 1'b0, 16'h0, 5'd0,  1'b0}, // R7 wrap
    '{3'd2, 2'd0, 16'h0,    6'd5,  RFA, 16'h0000, 1'b0, 16'h0, 5'd0,  1'b1}, // R8
    '{3'd3, 2'd0, 16'h0,    6'd0,  RFA, 16'h1233, 1'b1, 16'h1233, 5'd26, 1'b0}, // R9
    '{3'd3, 2'd1, 16'h0,    6'd0,  RFA, 16'hFFFF, 1'b1, 16'hFFFF, 5'd28, 1'b0}, // R9 wrap
    '{3'd4, 2'd2, 16'h0,    6'd0,  RFA, 16'hFFFF, 1'b1, 16'h0000, 5'd30, 1'b0}, // R10 wrap
    '{3'd4, 2'd0, 16'h0,    6'd0,  RFB, 16'h0000, 1'b1, 16'h0001, 5'd26, 1'b0}, // R10
    '{3'd2, 2'd1, 16'h0,    6'd0,  RFB, 16'h8001, 1'b0, 16'h0, 5'd0,  1'b0}, // R7 zero disp
    '{3'd1, 2'd2, 16'h0,    6'd0,  RFB, 16'h00FF, 1'b0, 16'h0, 5'd0,  1'b0}, // R6 R4
    '{3'd5, 2'd1, 16'h0,    6'd0,  RFA, 16'h0000, 1'b0, 16'h0, 5'd0,  1'b1}, // R11
    '{3'd3, 2'd3, 16'h0,    6'd0,  RFA, 16'h0000, 1'b0, 16'h0, 5'd0,  1'b1}, // R11
    '{3'd0, 2'd3, 16'h0000, 6'd9,  RFB, 16'h0000, 1'b0, 16'h0, 5'd0,  1'b0}  // R5 ptr ignored
  };

  function automatic string tagOf(logic [2:0] m, logic [1:0] p);
    case (m)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return (p == 2'd0) ? "R8" : "R7";
      3'd3: return (p == 2'd3) ? "R11" : "R9";
      3'd4: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "effValid in reset", 32'(effValid), 32'd0);
    check("R1", "wbEn in reset", 32'(wbEn), 32'd0);
    check("R1", "illegal in reset", 32'(illegal), 32'd0);
    check("R1", "effAddr in reset", 32'(effAddr), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "effValid after reset", 32'(effValid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = tagOf(VECS[i].mode, VECS[i].ptr);
      reqValid = 1'b1;
      reqMode = VECS[i].mode;
      reqPtr = VECS[i].ptr;
      directAddr = VECS[i].dir;
      disp = VECS[i].dsp;
      rfTop = VECS[i].rf;
      @(negedge clk);
      check("R2", "effValid", 32'(effValid), 32'd1);
      check(tg, "effAddr", 32'(effAddr), 32'(VECS[i].expAddr));
      check(tg, "wbEn (R12)", 32'(wbEn), 32'(VECS[i].expWb));
      check(tg, "illegal", 32'(illegal), 32'(VECS[i].expIll));
      if (VECS[i].expWb) begin
        check(tg, "wbValue", 32'(wbValue), 32'(VECS[i].expVal));
        check(tg, "wbRegLo", 32'(wbRegLo), 32'(VECS[i].expReg));
      end
    end

    // R2: idle cycle after an illegal request clears all strobes
    reqMode = 3'd7;
    @(negedge clk);
    reqValid = 1'b0;
    reqMode = 3'd3;
    @(negedge clk);
    check("R2", "effValid idle", 32'(effValid), 32'd0);
    check("R2", "wbEn idle", 32'(wbEn), 32'd0);
    check("R2", "illegal idle", 32'(illegal), 32'd0);

    // R3/R9: Z pre-decrement, distinct bytes, after idle
    reqValid = 1'b1;
    reqMode = 3'd3;
    reqPtr = 2'd2;
    rfTop = 48'h1200_0000_0000;
    @(negedge clk);
    check("R9", "effAddr Z borrow", 32'(effAddr), 32'h11FF);
    check("R9", "wbRegLo Z", 32'(wbRegLo), 32'd30);
    reqValid = 1'b0;

    // R1: reset mid-stream clears outputs
    reqValid = 1'b1;
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "effValid reset again", 32'(effValid), 32'd0);
    check("R1", "effAddr reset again", 32'(effAddr), 32'd0);
    reqValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule